// File: doc/BRIEF.md
# Single-Port RAM with Selectable Read-During-Write

This block is a synchronous memory with one port. A single address bus serves both reads and writes, and all activity happens on the rising edge of one clock. A read enable controls whether the read register loads. When it is low, the output keeps its last value.

Two elaboration-time parameters shape the read side. The first sets what a cycle that both reads and writes returns: either the word the location held before the write, or the word being written. The second adds a pipeline register after the read register, so that read data appears one or two cycles after the request.

The output registers clear on a synchronous active-high reset. The storage array does not reset. The data width and the depth are parameters, and the address width is derived from the depth.

Top module: `spram_rdw`

## Requirements
- R1: On a rising edge with `wr_en` high, `wr_data` is stored at `addr`. A later read of that address with `rd_en` high returns it. The address is `ceil(log2(DEPTH))` bits wide.
- R2: With `RDW_MODE = RDW_OLD`, an edge with both `rd_en` and `wr_en` high loads the read register with the word stored at `addr` before that write.
- R3: With `RDW_MODE = RDW_NEW`, an edge with both `rd_en` and `wr_en` high loads the read register with `wr_data` from that same edge.
- R4: On an edge with `rd_en` low, the read register keeps its value, whatever the address.
- R5: With `OUT_REG = 1`, `rd_data` shows the same sequence as with `OUT_REG = 0`, exactly one cycle later.
- R6: An edge with `rst` high clears every output register to zero, so `rd_data` reads zero after it.
- R7: A write with `rd_en` low updates memory but leaves `rd_data` unchanged.
- R8: Writes to the same address on back-to-back edges each take effect in order. In old mode, each of those cycles returns the value left by the previous write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all sampling occurs on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe; while low, the read register holds |
| rd_data | output | DATA_W | Read data, valid one cycle (`OUT_REG=0`) or two cycles (`OUT_REG=1`) after the request |

## Verification
A read or write presented before rising edge k lands in the read register at edge k. Without the extra stage, `rd_data` shows it from edge k onward. With the extra stage, it shows it only after edge k+1. The bench drives inputs on the falling edge and updates its reference array and expected registers on each rising edge. At the following falling edge, it compares all four parameter combinations (both modes, with and without the extra stage). The registered variants are expected to equal the unregistered expectation from the previous cycle, so every comparison is made at the cycle in which the value is due.

// File: rtl/spram_pkg.sv
package spram_pkg;

    typedef enum logic {
        RDW_OLD = 1'b0,
        RDW_NEW = 1'b1
    } rdw_mode_e;

    function automatic int addr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/spram_core.sv
module spram_core
    import spram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cur_word
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[addr] <= wr_data;
        end
    end

    assign cur_word = store[addr];

endmodule

// File: rtl/spram_rdsel.sv
module spram_rdsel
    import spram_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter rdw_mode_e RDW_MODE = RDW_OLD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] cur_word,
    output logic [DATA_W-1:0] rd_q
);

    logic [DATA_W-1:0] sel_word;

    generate
        if (RDW_MODE == RDW_NEW) begin : g_new
            assign sel_word = wr_en ? wr_data : cur_word;
        end else begin : g_old
            assign sel_word = cur_word;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= sel_word;
        end
    end

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

    generate
        if (RDW_MODE == RDW_NEW) begin : g_chk_new
            // R3
            rdw_new_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_en && wr_en) |=> (rd_q == $past(wr_data)));
        end else begin : g_chk_old
            // R2
            rdw_old_chk: assert property (@(posedge clk) disable iff (rst)
                (rd_en && wr_en) |=> (rd_q == $past(cur_word)));
        end
    endgenerate

endmodule

// File: rtl/spram_rdw.sv
module spram_rdw
    import spram_pkg::*;
#(
    parameter int        DATA_W   = 16,
    parameter int        DEPTH    = 64,
    parameter rdw_mode_e RDW_MODE = RDW_OLD,
    parameter bit        OUT_REG  = 1'b0,
    localparam int       ADDR_W   = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] rd_q;

    spram_core #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_core (
        .clk      (clk),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cur_word (cur_word)
    );

    spram_rdsel #(
        .DATA_W   (DATA_W),
        .RDW_MODE (RDW_MODE)
    ) u_rdsel (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .cur_word (cur_word),
        .rd_q     (rd_q)
    );

    generate
        if (OUT_REG) begin : g_pipe
            logic [DATA_W-1:0] pipe_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= rd_q;
                end
            end

            assign rd_data = pipe_q;

            // R5
            pipe_delay_chk: assert property (@(posedge clk) disable iff (rst)
                !rst |=> (rd_data == $past(rd_q)));
        end else begin : g_direct
            assign rd_data = rd_q;
        end
    endgenerate

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: tb/test_spram_rdw.sv
module test_spram_rdw;
    import spram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int DEP        = 16;
    localparam int AW         = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [DW-1:0] q_old, q_new, q_old_r, q_new_r;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW-1:0] ref_mem [DEP];
    logic [DW-1:0] e_old, e_new, e_old_r, e_new_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    spram_rdw #(.DATA_W(DW), .DEPTH(DEP), .RDW_MODE(RDW_OLD), .OUT_REG(1'b0)) i_spram_rdw (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(q_old));
    spram_rdw #(.DATA_W(DW), .DEPTH(DEP), .RDW_MODE(RDW_NEW), .OUT_REG(1'b0)) i_spram_rdw_new (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(q_new));
    spram_rdw #(.DATA_W(DW), .DEPTH(DEP), .RDW_MODE(RDW_OLD), .OUT_REG(1'b1)) i_spram_rdw_old_r (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(q_old_r));
    spram_rdw #(.DATA_W(DW), .DEPTH(DEP), .RDW_MODE(RDW_NEW), .OUT_REG(1'b1)) i_spram_rdw_new_r (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(q_new_r));

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string tag, input string who);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual %h expected %h at %0t", tag, who, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, take one rising edge, update model, compare.
    task automatic step(input logic r, input int a, input logic we, input int wd,
                        input logic re, input string tag_old, input string tag_new);
        rst     = r;
        addr    = AW'(a);
        wr_en   = we;
        wr_data = DW'(wd);
        rd_en   = re;
        @(posedge clk);
        if (r) begin
            e_old = '0; e_new = '0; e_old_r = '0; e_new_r = '0;
        end else begin
            e_old_r = e_old;
            e_new_r = e_new;
            if (re) begin
                e_old = ref_mem[a];
                e_new = we ? DW'(wd) : ref_mem[a];
            end
        end
        if (we) ref_mem[a] = DW'(wd);
        @(negedge clk);
        check(q_old,   e_old,   tag_old, "old");
        check(q_new,   e_new,   tag_new, "new");
        check(q_old_r, e_old_r, r ? "R6" : "R5", "old+reg");
        check(q_new_r, e_new_r, r ? "R6" : "R5", "new+reg");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        @(negedge clk);
        // R6: reset state
        step(1, 0, 0, 0, 0, "R6", "R6");
        step(1, 0, 0, 0, 1, "R6", "R6");
        // R7: fill memory with reads off; outputs must stay at zero
        for (int a = 0; a < DEP; a++) step(0, a, 1, a * 7 + 3, 0, "R7", "R7");
        // R1: plain reads of every location
        for (int a = 0; a < DEP; a++) step(0, a, 0, 0, 1, "R1", "R1");
        // R2 / R3: reads that write at the same time
        for (int a = 0; a < DEP; a += 3) step(0, a, 1, 8'hA0 + a, 1, "R2", "R3");
        // R8: back-to-back writes to one address with reads on
        step(0, 5, 1, 8'h11, 1, "R8", "R8");
        step(0, 5, 1, 8'h22, 1, "R8", "R8");
        step(0, 5, 1, 8'h33, 1, "R8", "R8");
        step(0, 5, 0, 0,     1, "R8", "R8");
        // R4: read enable low while the address moves
        for (int a = 0; a < 6; a++) step(0, a, 0, 0, 0, "R4", "R4");
        // R7: write with read off, then read it back (R1)
        step(0, 9, 1, 8'h5C, 0, "R7", "R7");
        step(0, 9, 0, 0,     1, "R1", "R1");
        // R2 / R3 again, with alternating addresses
        step(0, 2, 1, 8'hE1, 1, "R2", "R3");
        step(0, 3, 1, 8'hE2, 1, "R2", "R3");
        step(0, 2, 0, 0,     1, "R1", "R1");
        // R6: reset mid-run, then recover
        step(1, 4, 0, 0, 1, "R6", "R6");
        step(0, 4, 0, 0, 1, "R1", "R1");
        step(0, 4, 0, 0, 0, "R4", "R4");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule